// File: doc/BRIEF.md
# Per-Pin GPIO Control Slice

This block is the control and status slice for one pin of a multi-function I/O bank. A control word selects which of several peripheral functions drives the pad, or that no function is connected. Two override multiplexers then act on the selected signals. Each one can pass the output value or the output enable through, invert it, or force it low or high. The same slice watches the pad input through a synchroniser. It keeps sticky flags for rising and falling edges and combines them with live level conditions into one interrupt output for the pin.

Software reaches the slice through a 32-bit word port. The status word is at offset 0 and the control word at offset 4, so each pin takes an 8-byte stride in the bank. The bank is assumed to decode the pin index from the address bits between. The two top address bits select an alias:
- 00 writes the control word normally.
- 10 sets only the bits written as one.
- 11 clears only the bits written as one.
- 01 is an unused hole.

Writing bit 28 as one through the set alias discards the pin's latched edge events. Software does this when it acknowledges or disables the interrupt.

The interrupt path is a chain of registers: synchroniser stages, a previous-sample register and the two edge flags. The edge flags have two states, idle and latched. A flag moves from idle to latched on a detected edge. It moves back to idle on an event-reset write that arrives with no new edge in the same cycle.

Top module: `gpio_pin_slice`

## Requirements
- R1: After reset the control word reads 0x0000001F (function select 0x1F, both overrides 0, all interrupt enables 0). The status word reads 0, and pad_out, pad_oe and irq are 0.
- R2: The control word has these fields: function select in bits [4:0], output-value override in [13:12], output-enable override in [15:14] and interrupt-type enables in [23:20]. A normal write at offset 4 (alias bits 00) stores exactly these fields. All other bits read as 0.
- R3: A write with alias bits 10 (offset 0x2004) ORs the written one-bits into the control fields. A write with alias bits 11 (offset 0x3004) clears them. A read through either alias returns the control word.
- R4: For a function select f below NUM_FUNC (9 by default), pad_out and pad_oe take func_out[f] and func_oe[f] before the overrides. Value 5 is the plain GPIO pair. Any value of NUM_FUNC or above, including 0x1F, gives 0 and 0 before the overrides.
- R5: The output-value override codes are: 0 passes the selected value, 1 inverts it, 2 forces pad_out low and 3 forces it high.
- R6: The output-enable override codes are: 0 passes the selected enable, 1 inverts it, 2 forces pad_oe low and 3 forces it high.
- R7: pad_in passes through a 2-flop synchroniser. Status bit 0 and the level interrupt terms follow pad_in after two clock edges.
- R8: A rising edge of the synchronised input sets status bit 2, and a falling edge sets status bit 1. Each flag appears three edges after the pad change and stays set until it is reset.
- R9: Writing bit 28 as one through the set alias clears both edge flags. Bit 28 in a normal or clear-alias write has no effect, and bit 28 always reads 0. An edge detected in the same cycle as the reset still sets its flag.
- R10: The interrupt-type enable bits are: bit 20 falling edge, bit 21 rising edge, bit 22 level low, bit 23 level high. irq (also status bit 3) is the OR of latched-falling AND bit 20, latched-rising AND bit 21, input-low AND bit 22, and input-high AND bit 23. With no enable set, irq is 0.
- R11: Writes to the status word, or to the hole with alias bits 01, leave the control word unchanged. Reads from the hole return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W (14) | Byte address: alias in the top two bits, word select in bit 2 |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| func_out | input | NUM_FUNC (9) | Output value from each peripheral function |
| func_oe | input | NUM_FUNC (9) | Output enable from each peripheral function |
| pad_in | input | 1 | Asynchronous pad input |
| pad_out | output | 1 | Output value driven to the pad |
| pad_oe | output | 1 | Output enable driven to the pad |
| irq | output | 1 | Pin interrupt request |

## Verification
A register write takes effect at the clock edge that captures it. The bench checks the control read-back, pad_out and pad_oe half a cycle after that edge, because the pad path is combinational from the stored fields. The status level bit and the level interrupt are due two edges after a pad change, and the edge flags three edges after. The bench checks one edge early, where the old value must still hold, and again at the due edge. The same-cycle race between an edge and an event reset is set up so that the reset write is captured on the third edge after the pad change, exactly when the rising flag would latch.

// File: rtl/gpio_slice_pkg.sv
package gpio_slice_pkg;

    typedef enum logic [1:0] {
        OVR_PASS   = 2'd0,
        OVR_INVERT = 2'd1,
        OVR_LOW    = 2'd2,
        OVR_HIGH   = 2'd3
    } ovr_e;

    typedef enum logic [1:0] {
        ALIAS_NORMAL = 2'd0,
        ALIAS_HOLE   = 2'd1,
        ALIAS_SET    = 2'd2,
        ALIAS_CLEAR  = 2'd3
    } alias_e;

    typedef struct packed {
        logic [3:0] irq_en;
        ovr_e       oe_ovr;
        ovr_e       out_ovr;
        logic [4:0] fsel;
    } ctl_t;

    localparam int          WORD_W      = 32;
    localparam int          FSEL_LSB    = 0;
    localparam int          OUT_OVR_LSB = 12;
    localparam int          OE_OVR_LSB  = 14;
    localparam int          IRQ_EN_LSB  = 20;
    localparam int          EVT_RST_BIT = 28;
    localparam logic [4:0]  FSEL_NONE   = 5'h1F;

    localparam int IRQ_FALL = 0;
    localparam int IRQ_RISE = 1;
    localparam int IRQ_LOW  = 2;
    localparam int IRQ_HIGH = 3;

    localparam logic [WORD_W-1:0] CTL_MASK =
        (WORD_W'(32'h1F) << FSEL_LSB) | (WORD_W'(32'h3) << OUT_OVR_LSB) |
        (WORD_W'(32'h3) << OE_OVR_LSB) | (WORD_W'(32'hF) << IRQ_EN_LSB);

    function automatic logic [WORD_W-1:0] ctl_to_word(input ctl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[FSEL_LSB +: 5]    = c.fsel;
        w[OUT_OVR_LSB +: 2] = c.out_ovr;
        w[OE_OVR_LSB +: 2]  = c.oe_ovr;
        w[IRQ_EN_LSB +: 4]  = c.irq_en;
        return w;
    endfunction

    function automatic ctl_t word_to_ctl(input logic [WORD_W-1:0] w);
        ctl_t c;
        c.fsel    = w[FSEL_LSB +: 5];
        c.out_ovr = ovr_e'(w[OUT_OVR_LSB +: 2]);
        c.oe_ovr  = ovr_e'(w[OE_OVR_LSB +: 2]);
        c.irq_en  = w[IRQ_EN_LSB +: 4];
        return c;
    endfunction

    function automatic logic apply_ovr(input ovr_e mode, input logic sig);
        logic r;
        unique case (mode)
            OVR_PASS:   r = sig;
            OVR_INVERT: r = ~sig;
            OVR_LOW:    r = 1'b0;
            OVR_HIGH:   r = 1'b1;
            default:    r = sig;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_slice_regs.sv
module gpio_slice_regs
    import gpio_slice_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] status_word,
    output ctl_t              ctl,
    output logic [WORD_W-1:0] rdata,
    output logic              evt_reset
);

    localparam int ALIAS_LSB = ADDR_W - 2;

    alias_e            alias_sel;
    logic              is_ctl;
    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] wmask;
    logic [WORD_W-1:0] nxt_word;
    logic              ctl_wr;
    ctl_t              ctl_q;

    assign alias_sel = alias_e'(addr[ALIAS_LSB +: 2]);
    assign is_ctl    = addr[2];
    assign cur_word  = ctl_to_word(ctl_q);
    assign wmask     = wdata & CTL_MASK;
    assign ctl_wr    = wr_en && is_ctl && (alias_sel != ALIAS_HOLE);
    assign evt_reset = wr_en && is_ctl && (alias_sel == ALIAS_SET) && wdata[EVT_RST_BIT];

    always_comb begin
        unique case (alias_sel)
            ALIAS_NORMAL: nxt_word = wmask;
            ALIAS_SET:    nxt_word = cur_word | wmask;
            ALIAS_CLEAR:  nxt_word = cur_word & ~wmask;
            default:      nxt_word = cur_word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{irq_en: 4'h0, oe_ovr: OVR_PASS, out_ovr: OVR_PASS, fsel: FSEL_NONE};
        end else if (ctl_wr) begin
            ctl_q <= word_to_ctl(nxt_word);
        end
    end

    always_comb begin
        if (alias_sel == ALIAS_HOLE) begin
            rdata = '0;
        end else if (is_ctl) begin
            rdata = cur_word;
        end else begin
            rdata = status_word;
        end
    end

    assign ctl = ctl_q;

    logic unused_addr;
    assign unused_addr = ^{addr[ALIAS_LSB-1:3], addr[1:0]};

    // R3
    set_alias_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_ctl && alias_sel == ALIAS_SET) |=>
        ((ctl_to_word(ctl_q) & $past(cur_word)) == $past(cur_word)));

    // R3
    clear_alias_drops_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_ctl && alias_sel == ALIAS_CLEAR) |=>
        ((ctl_to_word(ctl_q) & $past(wdata)) == '0));

    // R11
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (!is_ctl || alias_sel == ALIAS_HOLE)) |=> $stable(ctl_q));

endmodule

// File: rtl/gpio_slice_mux.sv
module gpio_slice_mux
    import gpio_slice_pkg::*;
#(
    parameter int NUM_FUNC = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  ctl_t                ctl,
    input  logic [NUM_FUNC-1:0] func_out,
    input  logic [NUM_FUNC-1:0] func_oe,
    output logic                pad_out,
    output logic                pad_oe
);

    logic sel_out;
    logic sel_oe;
    logic connected;

    always_comb begin
        sel_out   = 1'b0;
        sel_oe    = 1'b0;
        connected = 1'b0;
        for (int i = 0; i < NUM_FUNC; i++) begin
            if (ctl.fsel == 5'(i)) begin
                sel_out   = func_out[i];
                sel_oe    = func_oe[i];
                connected = 1'b1;
            end
        end
    end

    assign pad_out = apply_ovr(ctl.out_ovr, sel_out);
    assign pad_oe  = apply_ovr(ctl.oe_ovr, sel_oe);

    // R4
    unconnected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!connected && ctl.out_ovr == OVR_PASS && ctl.oe_ovr == OVR_PASS) |-> (!pad_out && !pad_oe));

    // R5
    force_high_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.out_ovr == OVR_HIGH) |-> pad_out);

    // R6
    force_off_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.oe_ovr == OVR_LOW) |-> !pad_oe);

endmodule

// File: rtl/gpio_slice_irq.sv
module gpio_slice_irq
    import gpio_slice_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pad_in,
    input  logic       evt_reset,
    input  logic [3:0] irq_en,
    output logic       in_sync,
    output logic       fall_q,
    output logic       rise_q,
    output logic       irq
);

    logic [SYNC_STAGES-1:0] sync_r;
    logic                   prev_q;
    logic                   rise_evt;
    logic                   fall_evt;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_r <= '0;
                else        sync_r <= pad_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_r <= '0;
                else        sync_r <= {sync_r[SYNC_STAGES-2:0], pad_in};
            end
        end
    endgenerate

    assign in_sync  = sync_r[SYNC_STAGES-1];
    assign rise_evt = in_sync && !prev_q;
    assign fall_evt = !in_sync && prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            prev_q <= in_sync;
            rise_q <= rise_evt || (rise_q && !evt_reset);
            fall_q <= fall_evt || (fall_q && !evt_reset);
        end
    end

    assign irq = (rise_q && irq_en[IRQ_RISE]) || (fall_q && irq_en[IRQ_FALL]) ||
                 (in_sync && irq_en[IRQ_HIGH]) || (!in_sync && irq_en[IRQ_LOW]);

    // R8
    rise_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_q && !evt_reset) |=> rise_q);

    // R8
    fall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_q && !evt_reset) |=> fall_q);

    // R9
    reset_clears_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_reset && !rise_evt) |=> !rise_q);

    // R10
    no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 4'h0) |-> !irq);

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_slice_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int NUM_FUNC    = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_FUNC-1:0] func_out,
    input  logic [NUM_FUNC-1:0] func_oe,
    input  logic                pad_in,
    output logic                pad_out,
    output logic                pad_oe,
    output logic                irq
);

    ctl_t        ctl;
    logic        evt_reset;
    logic        in_sync;
    logic        fall_q;
    logic        rise_q;
    logic        irq_w;
    logic [31:0] status_word;

    assign status_word = {28'h0, irq_w, rise_q, fall_q, in_sync};
    assign irq         = irq_w;

    gpio_slice_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (reg_addr),
        .wr_en       (reg_wr),
        .wdata       (reg_wdata),
        .status_word (status_word),
        .ctl         (ctl),
        .rdata       (reg_rdata),
        .evt_reset   (evt_reset)
    );

    gpio_slice_mux #(.NUM_FUNC(NUM_FUNC)) mux_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .func_out (func_out),
        .func_oe  (func_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    gpio_slice_irq #(.SYNC_STAGES(SYNC_STAGES)) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_in    (pad_in),
        .evt_reset (evt_reset),
        .irq_en    (ctl.irq_en),
        .in_sync   (in_sync),
        .fall_q    (fall_q),
        .rise_q    (rise_q),
        .irq       (irq_w)
    );

endmodule

// File: tb/gpio_pin_slice_tb_top.sv
module gpio_pin_slice_tb_top;

    localparam int AW = 14;
    localparam int NF = 9;
    localparam logic [AW-1:0] A_STAT = 14'h0000;
    localparam logic [AW-1:0] A_CTL  = 14'h0004;
    localparam logic [AW-1:0] A_HOLE = 14'h1004;
    localparam logic [AW-1:0] A_SET  = 14'h2004;
    localparam logic [AW-1:0] A_CLR  = 14'h3004;

    typedef struct packed {
        logic [4:0] fsel;
        logic [1:0] oo;
        logic [1:0] eo;
        logic [8:0] fo;
        logic [8:0] fe;
        logic       xo;
        logic       xe;
    } vec_t;

    // R4 R5 R6 stimulus and expected pad_out / pad_oe
    localparam vec_t VECS [10] = '{
        '{5'd5,  2'd0, 2'd0, 9'h020, 9'h020, 1'b1, 1'b1},
        '{5'd5,  2'd0, 2'd0, 9'h1DF, 9'h1DF, 1'b0, 1'b0},
        '{5'd0,  2'd0, 2'd0, 9'h001, 9'h000, 1'b1, 1'b0},
        '{5'd8,  2'd1, 2'd1, 9'h100, 9'h100, 1'b0, 1'b0},
        '{5'd8,  2'd1, 2'd1, 9'h000, 9'h000, 1'b1, 1'b1},
        '{5'd3,  2'd2, 2'd3, 9'h1FF, 9'h000, 1'b0, 1'b1},
        '{5'd3,  2'd3, 2'd2, 9'h000, 9'h1FF, 1'b1, 1'b0},
        '{5'd9,  2'd0, 2'd0, 9'h1FF, 9'h1FF, 1'b0, 1'b0},
        '{5'h1F, 2'd1, 2'd1, 9'h1FF, 9'h1FF, 1'b1, 1'b1},
        '{5'd2,  2'd0, 2'd1, 9'h004, 9'h004, 1'b1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NF-1:0] func_out = '0;
    logic [NF-1:0] func_oe = '0;
    logic          pad_in = 1'b0;
    logic          pad_out;
    logic          pad_oe;
    logic          irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_pin_slice #(.ADDR_W(AW), .NUM_FUNC(NF), .SYNC_STAGES(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .func_out  (func_out),
        .func_oe   (func_oe),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        @(negedge clk);
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(A_CTL, d);  chk("R1 ctl reset", d, 32'h0000001F);
        rd(A_STAT, d); chk("R1 status reset", d, 32'h0);
        chk("R1 pad_out", {31'b0, pad_out}, 32'h0);
        chk("R1 pad_oe", {31'b0, pad_oe}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R4 R5 R6 vector walk
        for (int i = 0; i < 10; i++) begin
            func_out = VECS[i].fo;
            func_oe  = VECS[i].fe;
            wr(A_CTL, {16'h0, VECS[i].eo, VECS[i].oo, 7'h0, VECS[i].fsel});
            chk($sformatf("R4/R5 pad_out vec%0d", i), {31'b0, pad_out}, {31'b0, VECS[i].xo});
            chk($sformatf("R4/R6 pad_oe vec%0d", i), {31'b0, pad_oe}, {31'b0, VECS[i].xe});
        end
        func_out = '0;
        func_oe  = '0;

        // R2 field mask
        wr(A_CTL, 32'hFFFFFFFF);
        rd(A_CTL, d); chk("R2 mask readback", d, 32'h00F0F01F);
        wr(A_CTL, 32'h0);
        rd(A_CTL, d); chk("R2 zero readback", d, 32'h0);

        // R3 aliases
        wr(A_CTL, 32'h00000005);
        wr(A_SET, 32'h00003000);
        rd(A_CTL, d); chk("R3 set alias", d, 32'h00003005);
        wr(A_CLR, 32'h00000001);
        rd(A_CTL, d); chk("R3 clear alias", d, 32'h00003004);
        rd(A_SET, d); chk("R3 read via set alias", d, 32'h00003004);

        // R11 writes with no effect
        wr(A_STAT, 32'hFFFFFFFF);
        rd(A_CTL, d); chk("R11 status write", d, 32'h00003004);
        wr(A_HOLE, 32'hFFFFFFFF);
        rd(A_CTL, d); chk("R11 hole write", d, 32'h00003004);
        rd(A_HOLE, d); chk("R11 hole read", d, 32'h0);

        // R7 synchroniser, level-high enable (bit 23)
        wr(A_CTL, 32'h00800000);
        pad_in = 1'b1;
        tick(1);
        rd(A_STAT, d); chk("R7 status one edge", d, 32'h0);
        chk("R7 irq one edge", {31'b0, irq}, 32'h0);
        tick(1);
        rd(A_STAT, d); chk("R7 status two edges", d, 32'h9);
        chk("R7 irq two edges", {31'b0, irq}, 32'h1);

        // R8 edge latching
        tick(1);
        rd(A_STAT, d); chk("R8 rise latched", d, 32'hD);
        pad_in = 1'b0;
        tick(2);
        rd(A_STAT, d); chk("R8 fall not yet", d, 32'h4);
        tick(1);
        rd(A_STAT, d); chk("R8 fall latched, rise sticky", d, 32'h6);

        // R10 interrupt combination
        wr(A_CTL, 32'h00200000); chk("R10 rise enable", {31'b0, irq}, 32'h1);
        wr(A_CTL, 32'h00100000); chk("R10 fall enable", {31'b0, irq}, 32'h1);
        wr(A_CTL, 32'h0);        chk("R10 no enable", {31'b0, irq}, 32'h0);
        wr(A_CTL, 32'h00400000); chk("R10 level low", {31'b0, irq}, 32'h1);
        wr(A_CTL, 32'h00800000); chk("R10 level high, input low", {31'b0, irq}, 32'h0);

        // R9 event reset
        wr(A_CTL, 32'h10000000);
        rd(A_CTL, d);  chk("R9 bit28 not stored", d, 32'h0);
        rd(A_STAT, d); chk("R9 normal write keeps flags", d, 32'h6);
        wr(A_CLR, 32'h10000000);
        rd(A_STAT, d); chk("R9 clear alias keeps flags", d, 32'h6);
        wr(A_SET, 32'h10000000);
        rd(A_STAT, d); chk("R9 set alias clears flags", d, 32'h0);
        pad_in = 1'b1;
        tick(2);
        wr(A_SET, 32'h10000000);
        rd(A_STAT, d); chk("R9 same-cycle edge wins", d, 32'h5);
        wr(A_SET, 32'h10000000);
        rd(A_STAT, d); chk("R9 later reset clears", d, 32'h1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule